// File: doc/BRIEF.md
# Descriptor Chain Walking DMA Controller

This block runs a linked list of transfer descriptors that software leaves in memory. It has no per-transfer address or length registers. Software gives it a head pointer, which names the first descriptor, and a stop pointer, which names the last descriptor to run. Each descriptor is eight 32-bit words. The controller reads the five words that matter through a simple request/acknowledge memory port. It hands the buffer address, length, frame flags and stream identifiers to an external data mover and waits until the mover reports that the transfer is done. It then writes a completion status back into the descriptor and follows the link word to the next descriptor.

The walk ends once the descriptor at the stop pointer has been written back. Writing the stop pointer again later continues the chain from the link word of that last descriptor. This lets software append work to the chain without rewriting the head pointer. The controller refuses a descriptor that already carries a completion mark, because that marks a stale or looping chain. It halts with an error flag instead of moving that buffer twice.

States of the walker:
- IDLE waits for a stop-pointer write.
- FETCH reads the descriptor words one at a time.
- CHECK inspects the stale mark and the length.
- XFER_GO pulses the mover start.
- XFER_WAIT waits for the mover's completion.
- WRITEBACK stores the status word.

Transitions:
- IDLE→FETCH happens on a stop write while running and error-free.
- FETCH→CHECK happens after the fifth word arrives.
- CHECK→IDLE happens on a stale descriptor.
- CHECK→WRITEBACK happens on zero length.
- CHECK→XFER_GO happens otherwise.
- XFER_GO→XFER_WAIT always happens.
- XFER_WAIT→WRITEBACK happens on mover completion.
- WRITEBACK→IDLE happens at the stop descriptor or when run is clear.
- WRITEBACK→FETCH happens otherwise.

Top module: `bd_chain_walker`

## Requirements
- R1: After reset the walker is idle and halted, the error flag is 0, the active-descriptor readback is 0, and no memory request or transfer start is raised.
- R2: A stop-pointer write (cfg_wr_sel=2) starts a walk only when run (bit 0 of a cfg_wr_sel=0 write) is 1 and the error flag is 0. Otherwise it issues no memory read and no transfer.
- R3: A fetch reads words 0, 2, 4, 6 and 7 of a descriptor, in that order, at descriptor address + 4×word. mem_req, mem_we and mem_addr hold steady until mem_ack.
- R4: xfer_start is a one-cycle pulse. Its fields come from the descriptor as follows:
  - xfer_addr is word 2.
  - xfer_len is word 6 bits 15:0.
  - xfer_sof is word 6 bit 27.
  - xfer_eof is word 6 bit 26.
  - xfer_src_id is word 4 bits 3:0.
  - xfer_dst_id is word 4 bits 11:8.
- R5: After the mover's done pulse, word 7 is written with bit 31 set and the bytes reported by xfer_bytes in bits 15:0. All other bits of word 7 are 0.
- R6: The walker follows word 0 as the link to the next descriptor. It returns to idle after the write-back of the descriptor whose address equals the stop pointer.
- R7: active_desc_o equals the address of the descriptor being processed while it is fetched, transferred and written back.
- R8: A stop-pointer write after a completed walk resumes at the link word of the last completed descriptor.
- R9: A fetched descriptor with word 7 bit 31 already set starts no transfer and gets no write-back. The walker goes idle with err_o=1 and halted_o=1. A control write with run=0 clears the error.
- R10: A descriptor with length 0 starts no transfer. It is written back as completed with 0 bytes.
- R11: A stop-pointer write in the same cycle as the write-back acknowledge of the former stop descriptor takes effect at once. The walk continues to the next descriptor.
- R12: A head-pointer write (cfg_wr_sel=1) while a walk is in progress is ignored.
- R13: Clearing run during a walk lets the current descriptor finish its write-back. The walker then halts with active_desc_o on that descriptor's link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | 0 control (bit 0 run), 1 head pointer, 2 stop pointer |
| cfg_wr_data | input | 32 | Configuration write data |
| active_desc_o | output | 32 | Address of the descriptor being processed |
| idle_o | output | 1 | Walker is in IDLE |
| halted_o | output | 1 | Idle with run clear or error set |
| err_o | output | 1 | Stale descriptor detected |
| mem_req | output | 1 | Descriptor memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data (status word) |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_start | output | 1 | Transfer start pulse |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | 16 | Buffer length in bytes |
| xfer_sof | output | 1 | Start-of-frame flag |
| xfer_eof | output | 1 | End-of-frame flag |
| xfer_src_id | output | 4 | Stream source identifier |
| xfer_dst_id | output | 4 | Stream destination identifier |
| xfer_done | input | 1 | Transfer finished pulse |
| xfer_bytes | input | 16 | Bytes actually moved |

## Verification
Two events can fall in the same cycle: the end-of-chain decision made on the write-back acknowledge of the stop descriptor, and a software write that moves the stop pointer further. The bench builds a two-descriptor extension and points the stop register at the first descriptor. At a falling edge it waits for the cycle where the memory model acknowledges the write-back to word 7 of that descriptor, and it drives the stop-pointer write so that both are sampled at the same rising edge. The walk counts as correct only if the second descriptor is also transferred and marked complete and the readback finishes on its address. A design that compares against the old stop value would halt after the first descriptor and fail the transfer-count and status checks.

// File: rtl/bdw_pkg.sv
package bdw_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_XFER_GO,
        S_XFER_WAIT,
        S_WRITEBACK
    } walk_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_HEAD = 2'd1;
    localparam logic [1:0] SEL_STOP = 2'd2;

    localparam int FETCH_STEPS = 5;
    localparam int STEP_W      = 3;

    localparam int SOF_BIT     = 27;
    localparam int EOF_BIT     = 26;
    localparam int DONE_BIT    = 31;
    localparam int DID_LSB     = 8;
    localparam logic [2:0] STATUS_WORD = 3'd7;

    // Word offset inside a descriptor for each fetch step.
    function automatic logic [2:0] step_word(input logic [STEP_W-1:0] step);
        logic [2:0] w;
        unique case (step)
            3'd0:    w = 3'd0;
            3'd1:    w = 3'd2;
            3'd2:    w = 3'd4;
            3'd3:    w = 3'd6;
            default: w = STATUS_WORD;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/bdw_cfg_regs.sv
module bdw_cfg_regs
    import bdw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic          run,
    output logic          stop_wr,
    output logic [AW-1:0] stop_eff,
    output logic          head_wr,
    output logic [AW-1:0] head_data,
    output logic          err_clr
);

    logic          ctrl_wr;
    logic [AW-1:0] stop_q;

    always_comb begin
        ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
        stop_wr   = wr_en && (wr_sel == SEL_STOP);
        head_wr   = wr_en && (wr_sel == SEL_HEAD);
        head_data = wr_data[AW-1:0];
        err_clr   = ctrl_wr && !wr_data[0];
        // A stop write in flight is already visible to the end-of-chain compare.
        stop_eff  = stop_wr ? wr_data[AW-1:0] : stop_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run    <= 1'b0;
            stop_q <= '0;
        end else begin
            if (ctrl_wr) run <= wr_data[0];
            if (stop_wr) stop_q <= wr_data[AW-1:0];
        end
    end

    assert_run_tracks_ctrl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (run == $past(wr_data[0])));

endmodule

// File: rtl/bdw_desc_latch.sv
module bdw_desc_latch
    import bdw_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int ID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [STEP_W-1:0] step,
    input  logic [DW-1:0]     rdata,
    output logic [AW-1:0]     next_ptr,
    output logic [AW-1:0]     buf_addr,
    output logic [LEN_W-1:0]  len,
    output logic              sof,
    output logic              eof,
    output logic [ID_W-1:0]   src_id,
    output logic [ID_W-1:0]   dst_id,
    output logic              already_done
);

    logic [DW-1:0] words_q [FETCH_STEPS];

    for (genvar g = 0; g < FETCH_STEPS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[g] <= '0;
            end else if (cap_en && (step == STEP_W'(g))) begin
                words_q[g] <= rdata;
            end
        end
    end

    always_comb begin
        next_ptr     = words_q[0][AW-1:0];
        buf_addr     = words_q[1][AW-1:0];
        src_id       = words_q[2][ID_W-1:0];
        dst_id       = words_q[2][DID_LSB+ID_W-1:DID_LSB];
        len          = words_q[3][LEN_W-1:0];
        sof          = words_q[3][SOF_BIT];
        eof          = words_q[3][EOF_BIT];
        already_done = words_q[4][DONE_BIT];
    end

    logic unused_bits;
    assign unused_bits = ^{words_q[0], words_q[1], words_q[2], words_q[3], words_q[4]};

endmodule

// File: rtl/bdw_walk_fsm.sv
module bdw_walk_fsm
    import bdw_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              stop_wr,
    input  logic [AW-1:0]     stop_eff,
    input  logic              head_wr,
    input  logic [AW-1:0]     head_data,
    input  logic              err_clr,
    input  logic [AW-1:0]     next_ptr,
    input  logic [LEN_W-1:0]  len,
    input  logic              already_done,
    output logic              cap_en,
    output logic [STEP_W-1:0] step,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    output logic              xfer_start,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_bytes,
    output logic [AW-1:0]     active_desc_o,
    output logic              idle_o,
    output logic              halted_o,
    output logic              err_o
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(FETCH_STEPS - 1);

    walk_state_e       state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic [AW-1:0]     cur_q;
    logic              resume_q;
    logic              err_q;
    logic [LEN_W-1:0]  bytes_q;
    logic              start_ok;
    logic              at_stop;

    assign start_ok = stop_wr && run && !err_q;
    assign at_stop  = (cur_q == stop_eff);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start_ok) state_d = S_FETCH;
            S_FETCH:     if (mem_ack && (step_q == LAST_STEP)) state_d = S_CHECK;
            S_CHECK: begin
                if (already_done)     state_d = S_IDLE;
                else if (len == '0)   state_d = S_WRITEBACK;
                else                  state_d = S_XFER_GO;
            end
            S_XFER_GO:   state_d = S_XFER_WAIT;
            S_XFER_WAIT: if (xfer_done) state_d = S_WRITEBACK;
            S_WRITEBACK: begin
                if (mem_ack) begin
                    if (at_stop || !run) state_d = S_IDLE;
                    else                 state_d = S_FETCH;
                end
            end
            default:     state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur_q;
        mem_wdata  = '0;
        xfer_start = 1'b0;
        cap_en     = 1'b0;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'({step_word(step_q), 2'b00});
                cap_en   = mem_ack;
            end
            S_WRITEBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_q + AW'({STATUS_WORD, 2'b00});
                mem_wdata[LEN_W-1:0] = bytes_q;
                mem_wdata[DONE_BIT]  = 1'b1;
            end
            S_XFER_GO:   xfer_start = 1'b1;
            default:     ;
        endcase
        step          = step_q;
        active_desc_o = cur_q;
        idle_o        = (state_q == S_IDLE);
        halted_o      = (state_q == S_IDLE) && (!run || err_q);
        err_o         = err_q;
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= '0;
            cur_q    <= '0;
            resume_q <= 1'b0;
            err_q    <= 1'b0;
            bytes_q  <= '0;
        end else begin
            if (err_clr) err_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (head_wr) begin
                        cur_q    <= head_data;
                        resume_q <= 1'b0;
                    end
                    if (start_ok) begin
                        step_q <= '0;
                        if (resume_q) begin
                            cur_q    <= next_ptr;
                            resume_q <= 1'b0;
                        end
                    end
                end
                S_FETCH: if (mem_ack) step_q <= step_q + 1'b1;
                S_CHECK: begin
                    if (already_done)   err_q   <= 1'b1;
                    else if (len == '0) bytes_q <= '0;
                end
                S_XFER_WAIT: if (xfer_done) bytes_q <= xfer_bytes;
                S_WRITEBACK: begin
                    if (mem_ack) begin
                        step_q <= '0;
                        if (at_stop) resume_q <= 1'b1;
                        else         cur_q    <= next_ptr;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    assert_wb_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[DONE_BIT] && (mem_addr[4:2] == STATUS_WORD)));

    assert_head_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != S_IDLE) && !(mem_we && mem_ack)) |=> $stable(active_desc_o));

    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (state_q == S_IDLE && !xfer_start));

    assert_no_stale_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !already_done);

    assert_no_empty_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (len != '0));

endmodule

// File: rtl/bd_chain_walker.sv
module bd_chain_walker
    import bdw_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [1:0]       cfg_wr_sel,
    input  logic [DW-1:0]    cfg_wr_data,
    output logic [AW-1:0]    active_desc_o,
    output logic             idle_o,
    output logic             halted_o,
    output logic             err_o,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             xfer_start,
    output logic [AW-1:0]    xfer_addr,
    output logic [LEN_W-1:0] xfer_len,
    output logic             xfer_sof,
    output logic             xfer_eof,
    output logic [ID_W-1:0]  xfer_src_id,
    output logic [ID_W-1:0]  xfer_dst_id,
    input  logic             xfer_done,
    input  logic [LEN_W-1:0] xfer_bytes
);

    logic              run, stop_wr, head_wr, err_clr;
    logic [AW-1:0]     stop_eff, head_data;
    logic              cap_en, already_done;
    logic [STEP_W-1:0] step;
    logic [AW-1:0]     next_ptr;

    bdw_cfg_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_wr_sel),
        .wr_data   (cfg_wr_data),
        .run       (run),
        .stop_wr   (stop_wr),
        .stop_eff  (stop_eff),
        .head_wr   (head_wr),
        .head_data (head_data),
        .err_clr   (err_clr)
    );

    bdw_desc_latch #(.DW(DW), .AW(AW), .LEN_W(LEN_W), .ID_W(ID_W)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_en       (cap_en),
        .step         (step),
        .rdata        (mem_rdata),
        .next_ptr     (next_ptr),
        .buf_addr     (xfer_addr),
        .len          (xfer_len),
        .sof          (xfer_sof),
        .eof          (xfer_eof),
        .src_id       (xfer_src_id),
        .dst_id       (xfer_dst_id),
        .already_done (already_done)
    );

    bdw_walk_fsm #(.DW(DW), .AW(AW), .LEN_W(LEN_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .stop_wr       (stop_wr),
        .stop_eff      (stop_eff),
        .head_wr       (head_wr),
        .head_data     (head_data),
        .err_clr       (err_clr),
        .next_ptr      (next_ptr),
        .len           (xfer_len),
        .already_done  (already_done),
        .cap_en        (cap_en),
        .step          (step),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .xfer_start    (xfer_start),
        .xfer_done     (xfer_done),
        .xfer_bytes    (xfer_bytes),
        .active_desc_o (active_desc_o),
        .idle_o        (idle_o),
        .halted_o      (halted_o),
        .err_o         (err_o)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!mem_req && !xfer_start));

endmodule

// File: tb/tb_bd_chain_walker.sv
`timescale 1ns/1ps
module tb_bd_chain_walker;

    localparam int DW = 32, AW = 32, LEN_W = 16, ID_W = 4;

    typedef struct packed {
        logic [31:0] buf_a;
        logic [15:0] len;
        logic        sof;
        logic        eof;
        logic [3:0]  sid;
        logic [3:0]  did;
    } vec_t;

    localparam vec_t VEC [0:3] = '{
        '{32'h1000_0000, 16'd64,  1'b1, 1'b0, 4'd1, 4'd2},
        '{32'h1000_0400, 16'd37,  1'b0, 1'b0, 4'd3, 4'd5},
        '{32'h1000_0800, 16'd256, 1'b0, 1'b0, 4'd0, 4'd15},
        '{32'h1000_0C00, 16'd8,   1'b0, 1'b1, 4'd2, 4'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             cfg_wr_en = 1'b0;
    logic [1:0]       cfg_wr_sel = '0;
    logic [DW-1:0]    cfg_wr_data = '0;
    logic [AW-1:0]    active_desc_o;
    logic             idle_o, halted_o, err_o;
    logic             mem_req, mem_we, mem_ack;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_wdata, mem_rdata;
    logic             xfer_start, xfer_sof, xfer_eof, xfer_done;
    logic [AW-1:0]    xfer_addr;
    logic [LEN_W-1:0] xfer_len, xfer_bytes;
    logic [ID_W-1:0]  xfer_src_id, xfer_dst_id;

    bd_chain_walker dut (.*);

    // Descriptor memory model: one-cycle acknowledge, host preload port
    logic [31:0] mem [0:127];
    logic        hw_en = 1'b0;
    logic [6:0]  hw_idx = '0;
    logic [31:0] hw_data = '0;
    logic [31:0] rd_log [0:255];
    logic [31:0] wr_log [0:63];
    int rd_n, wr_n;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            rd_n      <= 0;
            wr_n      <= 0;
        end else begin
            if (hw_en) mem[hw_idx] <= hw_data;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[8:2]] <= mem_wdata;
                    wr_log[wr_n[5:0]]  <= mem_addr;
                    wr_n               <= wr_n + 1;
                end else begin
                    mem_rdata          <= mem[mem_addr[8:2]];
                    rd_log[rd_n[7:0]]  <= mem_addr;
                    rd_n               <= rd_n + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // Data mover model: done three cycles after start, reports len - src_id
    logic [31:0] xf_addr [0:31];
    logic [15:0] xf_len  [0:31];
    logic [1:0]  xf_flag [0:31];
    logic [7:0]  xf_ids  [0:31];
    logic [31:0] xf_head [0:31];
    int xf_n, eng_cnt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_done  <= 1'b0;
            xfer_bytes <= '0;
            xf_n       <= 0;
            eng_cnt    <= 0;
        end else begin
            xfer_done <= 1'b0;
            if (xfer_start) begin
                xf_addr[xf_n[4:0]] <= xfer_addr;
                xf_len[xf_n[4:0]]  <= xfer_len;
                xf_flag[xf_n[4:0]] <= {xfer_sof, xfer_eof};
                xf_ids[xf_n[4:0]]  <= {xfer_src_id, xfer_dst_id};
                xf_head[xf_n[4:0]] <= active_desc_o;
                xf_n               <= xf_n + 1;
                xfer_bytes         <= xfer_len - 16'(xfer_src_id);
                eng_cnt            <= 3;
            end else if (eng_cnt > 0) begin
                eng_cnt <= eng_cnt - 1;
                if (eng_cnt == 1) xfer_done <= 1'b1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic mem_put(input int w, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_idx = w[6:0]; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic put_desc(input int idx, input logic [31:0] nxt, input logic [31:0] b,
                            input logic [15:0] len, input logic sof, input logic eof,
                            input logic [3:0] sid, input logic [3:0] did, input logic [31:0] st);
        mem_put(idx*8 + 0, nxt);
        mem_put(idx*8 + 1, 32'h0);
        mem_put(idx*8 + 2, b);
        mem_put(idx*8 + 3, 32'h0);
        mem_put(idx*8 + 4, {20'h0, did, 4'h0, sid});
        mem_put(idx*8 + 5, 32'h0);
        mem_put(idx*8 + 6, {4'h0, sof, eof, 10'h0, len});
        mem_put(idx*8 + 7, st);
    endtask

    task automatic wait_idle();
        int k = 0;
        @(negedge clk);
        while (!idle_o && k < 4000) begin
            @(negedge clk);
            k++;
        end
    endtask

    function automatic logic [31:0] exp_stat(input logic [15:0] len, input logic [3:0] sid);
        return 32'h8000_0000 | 32'(len - 16'(sid));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int wr_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 idle",   32'(idle_o), 32'd1);
        chk("R1 halted", 32'(halted_o), 32'd1);
        chk("R1 err",    32'(err_o), 32'd0);
        chk("R1 active", active_desc_o, 32'h0);
        chk("R1 req",    32'(mem_req | xfer_start), 32'd0);

        for (int i = 0; i < 4; i++)
            put_desc(i + 1, 32'((i + 2) * 32), VEC[i].buf_a, VEC[i].len, VEC[i].sof,
                     VEC[i].eof, VEC[i].sid, VEC[i].did, 32'h0);

        // R2 stop write without run does not start
        cfg(2'd1, 32'h20);
        cfg(2'd2, 32'h80);
        repeat (10) @(negedge clk);
        chk("R2 no read", 32'(rd_n), 32'd0);
        chk("R2 no xfer", 32'(xf_n), 32'd0);
        chk("R2 halted",  32'(halted_o), 32'd1);

        // Table walk: R3 R4 R5 R6 R7
        cfg(2'd0, 32'h1);
        cfg(2'd2, 32'h80);
        wait_idle();
        chk("R3 rd0", rd_log[0], 32'h20);
        chk("R3 rd1", rd_log[1], 32'h28);
        chk("R3 rd2", rd_log[2], 32'h30);
        chk("R3 rd3", rd_log[3], 32'h38);
        chk("R3 rd4", rd_log[4], 32'h3C);
        chk("R5 wb addr", wr_log[0], 32'h3C);
        for (int i = 0; i < 4; i++) begin
            chk("R4 addr",  xf_addr[i], VEC[i].buf_a);
            chk("R4 len",   32'(xf_len[i]), 32'(VEC[i].len));
            chk("R4 flags", 32'(xf_flag[i]), 32'({VEC[i].sof, VEC[i].eof}));
            chk("R4 ids",   32'(xf_ids[i]), 32'({VEC[i].sid, VEC[i].did}));
            chk("R7 head",  xf_head[i], 32'((i + 1) * 32));
            chk("R5 status", mem[(i + 1) * 8 + 7], exp_stat(VEC[i].len, VEC[i].sid));
        end
        chk("R6 count",  32'(xf_n), 32'd4);
        chk("R6 active", active_desc_o, 32'h80);
        chk("R6 idle",   32'(idle_o), 32'd1);
        chk("R6 no err", 32'(err_o), 32'd0);

        // R8 resume from link, R10 zero length
        put_desc(5, 32'hC0, 32'h2000_0000, 16'd20, 1'b1, 1'b1, 4'd0, 4'd1, 32'h0);
        put_desc(6, 32'hE0, 32'h2000_0100, 16'd0,  1'b0, 1'b0, 4'd0, 4'd0, 32'h0);
        cfg(2'd2, 32'hC0);
        wait_idle();
        chk("R8 head",   xf_head[4], 32'hA0);
        chk("R8 addr",   xf_addr[4], 32'h2000_0000);
        chk("R10 count", 32'(xf_n), 32'd5);
        chk("R10 status", mem[6 * 8 + 7], 32'h8000_0000);
        chk("R8 active", active_desc_o, 32'hC0);

        // R11 stop write coincides with write-back acknowledge of old stop
        put_desc(7, 32'h100, 32'h3000_0000, 16'd12, 1'b0, 1'b0, 4'd2, 4'd3, 32'h0);
        put_desc(8, 32'h120, 32'h3000_0100, 16'd40, 1'b0, 1'b1, 4'd4, 4'd6, 32'h0);
        cfg(2'd2, 32'hE0);
        begin
            int k = 0;
            while (!(mem_ack && mem_we && mem_addr == 32'hFC) && k < 4000) begin
                @(negedge clk);
                k++;
            end
        end
        cfg_wr_en = 1'b1; cfg_wr_sel = 2'd2; cfg_wr_data = 32'h100;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        wait_idle();
        chk("R11 count",  32'(xf_n), 32'd7);
        chk("R11 head",   xf_head[6], 32'h100);
        chk("R11 status", mem[8 * 8 + 7], exp_stat(16'd40, 4'd4));
        chk("R11 active", active_desc_o, 32'h100);

        // R12 head write during a walk is ignored
        put_desc(9, 32'h140, 32'h4000_0000, 16'd30, 1'b1, 1'b1, 4'd1, 4'd7, 32'h0);
        cfg(2'd2, 32'h120);
        cfg(2'd1, 32'h0);
        wait_idle();
        chk("R12 head",   xf_head[7], 32'h120);
        chk("R12 active", active_desc_o, 32'h120);
        chk("R12 status", mem[9 * 8 + 7], exp_stat(16'd30, 4'd1));

        // R9 stale descriptor
        put_desc(10, 32'h160, 32'h5000_0000, 16'd16, 1'b0, 1'b0, 4'd0, 4'd0, 32'h8000_0005);
        wr_before = wr_n;
        cfg(2'd2, 32'h140);
        wait_idle();
        chk("R9 err",      32'(err_o), 32'd1);
        chk("R9 halted",   32'(halted_o), 32'd1);
        chk("R9 no xfer",  32'(xf_n), 32'd8);
        chk("R9 no wb",    32'(wr_n), 32'(wr_before));
        chk("R9 kept",     mem[10 * 8 + 7], 32'h8000_0005);
        chk("R9 active",   active_desc_o, 32'h140);
        cfg(2'd0, 32'h0);
        chk("R9 cleared",  32'(err_o), 32'd0);

        // R13 run cleared mid-walk
        put_desc(11, 32'h180, 32'h6000_0000, 16'd50, 1'b0, 1'b0, 4'd3, 4'd2, 32'h0);
        put_desc(12, 32'h1A0, 32'h6000_0100, 16'd22, 1'b0, 1'b0, 4'd1, 4'd1, 32'h0);
        cfg(2'd1, 32'h160);
        cfg(2'd0, 32'h1);
        cfg(2'd2, 32'h180);
        begin
            int k = 0;
            while (xf_n < 9 && k < 4000) begin
                @(negedge clk);
                k++;
            end
        end
        cfg(2'd0, 32'h0);
        wait_idle();
        chk("R13 count",  32'(xf_n), 32'd9);
        chk("R13 status", mem[11 * 8 + 7], exp_stat(16'd50, 4'd3));
        chk("R13 untouched", mem[12 * 8 + 7], 32'h0);
        chk("R13 active", active_desc_o, 32'h180);
        chk("R13 halted", 32'(halted_o), 32'd1);
        cfg(2'd0, 32'h1);
        cfg(2'd2, 32'h180);
        wait_idle();
        chk("R13 restart count", 32'(xf_n), 32'd10);
        chk("R13 restart head",  xf_head[9], 32'h180);
        chk("R13 restart status", mem[12 * 8 + 7], exp_stat(16'd22, 4'd1));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule